// File: doc/BRIEF.md
# Mode Register Read Result Buffer

This block holds the words that come back from DRAM mode-register reads so that software can fetch them over APB. A capture port, qualified by a one-cycle strobe, writes each returned word into a twelve-entry store. A status register at offset 0x518 shows whether results are present and how many words have arrived since the buffer was last emptied. Twelve word-spaced data registers, from 0x51C to 0x548, show the stored entries relative to a read pointer.

Software reads the status register, then reads data register 0 to fetch the first result. Each read of data register 0 that returns a stored entry moves the read pointer forward by one. A read of the last data register, at 0x548, rewinds the read pointer and clears the status register. The controller pulses a clear input when it starts a new mode-register read, and that pulse empties the buffer. The APB side has no wait states. The block has no write data path, and any write to its offsets has no effect.

Top module: `mrr_result_buf`

## Requirements
- R1: After reset, the status register (0x518) reads 0 and every data register (0x51C + 4*n, n = 0..11) reads 0.
- R2: Each cycle with `cap_valid` high stores `cap_data` at the next free entry, in arrival order. While the read pointer is 0, data register n returns entry n.
- R3: Status bit 0 is 1 when the entry count is nonzero. Bits 3:1 hold the count of captures made since the last clear or rewind, and the count saturates at 7. Bits 31:4 read 0.
- R4: After twelve entries have been stored, further captures are dropped and do not change any stored word. They still raise the count, up to its limit of 7.
- R5: A data register whose entry index (read pointer + n) has not been written since the last clear reads 0.
- R6: An APB read of data register 0 advances the read pointer by one when the entry at the pointer has been written. After that, data register n returns entry (read pointer + n).
- R7: An APB read of data register 11 (0x548) sets the read pointer to 0 and the count to 0. Stored words stay readable, and later captures append after them.
- R8: A `mrr_clr` pulse empties the buffer: the status reads 0, all data registers read 0, and the next capture goes to entry 0. A capture in the same cycle as `mrr_clr` is discarded.
- R9: A capture in the same cycle as a data register 11 read is applied after the rewind, so the status then reads 0x3.
- R10: `pready` is always high. `prdata` is valid in the access phase of the same transfer. APB writes change nothing. Unmapped offsets and offsets that are not word-aligned read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mrr_clr | input | 1 | Empties the buffer at the start of a new mode-register read |
| cap_valid | input | 1 | Strobe that qualifies `cap_data` |
| cap_data | input | 32 | Returned mode-register word |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction; writes are ignored |
| paddr | input | 12 | APB byte offset |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |

## Verification
`prdata` is combinational from `paddr` and the stored state, so the bench samples it 1 ns after the falling edge of the access phase, before the edge that completes the transfer. A capture, a clear, a pop or a rewind takes effect at the rising edge of the cycle in which it is driven. The bench therefore updates its model at that edge and expects the new value from the next transfer onward. Reset passes through a two-stage synchronizer, so the bench waits several cycles after releasing reset before it makes the first check.

// File: rtl/mrr_buf_pkg.sv
package mrr_buf_pkg;
  localparam int DEF_DATA_W = 32;
  localparam int DEF_ADDR_W = 12;
  localparam int DEF_DEPTH  = 12;
  localparam int DEF_CNT_W  = 3;
  localparam logic [DEF_ADDR_W-1:0] DEF_STATUS_OFF = 12'h518;
  localparam logic [DEF_ADDR_W-1:0] DEF_DATA0_OFF  = 12'h51C;

  typedef enum logic [1:0] {
    REG_NONE   = 2'd0,
    REG_STATUS = 2'd1,
    REG_DATA   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/mrr_apb_decode.sv
module mrr_apb_decode
  import mrr_buf_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DEPTH  = DEF_DEPTH,
  parameter logic [ADDR_W-1:0] STATUS_OFF = DEF_STATUS_OFF,
  parameter logic [ADDR_W-1:0] DATA0_OFF  = DEF_DATA0_OFF,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  data_idx,
  output logic              pop_req,
  output logic              rewind_req
);
  localparam logic [ADDR_W-3:0] D0_WORD = DATA0_OFF[ADDR_W-1:2];
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(DEPTH - 1);

  logic [ADDR_W-3:0] word_off;
  logic              in_data;
  logic              rd_access;

  always_comb begin
    word_off  = paddr[ADDR_W-1:2] - D0_WORD;
    in_data   = (paddr[1:0] == 2'b00) && (paddr[ADDR_W-1:2] >= D0_WORD) &&
                (word_off < (ADDR_W-2)'(DEPTH));
    data_idx  = word_off[IDX_W-1:0];
    rd_access = psel && penable && !pwrite;

    if (paddr == STATUS_OFF) sel = REG_STATUS;
    else if (in_data)        sel = REG_DATA;
    else                     sel = REG_NONE;

    pop_req    = rd_access && (sel == REG_DATA) && (data_idx == '0);
    rewind_req = rd_access && (sel == REG_DATA) && (data_idx == LAST_IDX);
  end
endmodule

// File: rtl/mrr_capture_store.sv
module mrr_capture_store
  import mrr_buf_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int DEPTH  = DEF_DEPTH,
  parameter int CNT_W  = DEF_CNT_W,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap_valid,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              rewind,
  input  logic [PTR_W:0]    rd_idx,
  output logic [DATA_W-1:0] rd_word,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_d;
  logic [CNT_W-1:0]  count_d, cnt_base;
  logic              store_en;

  always_comb begin
    store_en = cap_valid && !clr && (wr_ptr < PTR_W'(DEPTH));
    cnt_base = rewind ? '0 : count;
    count_d  = (cap_valid && cnt_base != CNT_MAX) ? cnt_base + 1'b1 : cnt_base;
    wr_ptr_d = store_en ? wr_ptr + 1'b1 : wr_ptr;
    if (clr) begin
      count_d  = '0;
      wr_ptr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      count  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (store_en) mem[wr_ptr[IDX_W-1:0]] <= cap_data;
  end

  always_comb begin
    if (rd_idx < (PTR_W+1)'(wr_ptr)) rd_word = mem[rd_idx[IDX_W-1:0]];
    else                             rd_word = '0;
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= PTR_W'(DEPTH));
  assert_cnt_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && cap_valid && !clr && !rewind) |=> (count == CNT_MAX));
  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && wr_ptr == '0));
  assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr == PTR_W'(DEPTH) && !clr) |=> (wr_ptr == PTR_W'(DEPTH)));
endmodule

// File: rtl/mrr_read_ptr.sv
module mrr_read_ptr
  import mrr_buf_pkg::*;
#(
  parameter int DEPTH  = DEF_DEPTH,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             pop,
  input  logic             rewind,
  input  logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr
);
  logic [PTR_W-1:0] rd_ptr_d;

  always_comb begin
    rd_ptr_d = rd_ptr;
    if (clr || rewind)                rd_ptr_d = '0;
    else if (pop && rd_ptr < wr_ptr)  rd_ptr_d = rd_ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_ptr <= '0;
    else        rd_ptr <= rd_ptr_d;
  end

  assert_rewind_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (rd_ptr == '0));
  assert_pop_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr && rd_ptr < wr_ptr) |=> (rd_ptr == $past(rd_ptr) + 1'b1));
endmodule

// File: rtl/mrr_result_buf.sv
module mrr_result_buf
  import mrr_buf_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int DEPTH  = DEF_DEPTH,
  parameter int CNT_W  = DEF_CNT_W,
  parameter logic [ADDR_W-1:0] STATUS_OFF = DEF_STATUS_OFF,
  parameter logic [ADDR_W-1:0] DATA0_OFF  = DEF_DATA0_OFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mrr_clr,
  input  logic              cap_valid,
  input  logic [DATA_W-1:0] cap_data,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic [DATA_W-1:0] prdata,
  output logic              pready
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int SUM_W = PTR_W + 1;

  logic              rst_meta, rst_n_int;
  reg_sel_e          sel;
  logic [IDX_W-1:0]  data_idx;
  logic              pop_req, rewind_req;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;
  logic [SUM_W-1:0]  rd_idx;
  logic [DATA_W-1:0] rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_n_int <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_n_int <= rst_meta;
    end
  end

  mrr_apb_decode #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .STATUS_OFF(STATUS_OFF), .DATA0_OFF(DATA0_OFF)
  ) u_decode (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .sel(sel), .data_idx(data_idx), .pop_req(pop_req), .rewind_req(rewind_req)
  );

  assign rd_idx = SUM_W'(rd_ptr) + SUM_W'(data_idx);

  mrr_capture_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n_int), .clr(mrr_clr), .cap_valid(cap_valid),
    .cap_data(cap_data), .rewind(rewind_req), .rd_idx(rd_idx),
    .rd_word(rd_word), .wr_ptr(wr_ptr), .count(count)
  );

  mrr_read_ptr #(
    .DEPTH(DEPTH)
  ) u_rptr (
    .clk(clk), .rst_n(rst_n_int), .clr(mrr_clr), .pop(pop_req),
    .rewind(rewind_req), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr)
  );

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (sel)
        REG_STATUS: prdata = {{(DATA_W-CNT_W-1){1'b0}}, count, (count != '0)};
        REG_DATA:   prdata = rd_word;
        default:    prdata = '0;
      endcase
    end
  end

  assign pready = 1'b1;

  assert_ptr_order_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    rd_ptr <= wr_ptr);
  assert_write_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    (psel && penable && pwrite && !mrr_clr && !cap_valid) |=>
      ($stable(count) && $stable(wr_ptr) && $stable(rd_ptr)));
endmodule

// File: tb/mrr_result_buf_tb.sv
`timescale 1ns/1ps
module mrr_result_buf_tb;
  localparam logic [11:0] ST_OFF = 12'h518;
  localparam logic [11:0] D0_OFF = 12'h51C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mrr_clr, cap_valid, psel, penable, pwrite;
  logic [31:0] cap_data, prdata;
  logic [11:0] paddr;
  logic        pready;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [31:0] m_mem [12];
  int m_wr, m_rd, m_cnt;

  always #10 clk = ~clk;

  mrr_result_buf u_dut (
    .clk(clk), .rst_n(rst_n), .mrr_clr(mrr_clr), .cap_valid(cap_valid),
    .cap_data(cap_data), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .prdata(prdata), .pready(pready)
  );

  function automatic logic [31:0] dreg(int n);
    return D0_OFF + 12'(4 * n);
  endfunction

  function automatic logic [31:0] m_expect(logic [11:0] a);
    int idx;
    if (a == ST_OFF) return {28'd0, 3'(m_cnt), (m_cnt != 0)};
    if (a[1:0] == 2'b00 && a >= D0_OFF && a <= dreg(11)) begin
      idx = m_rd + int'((a - D0_OFF) >> 2);
      return (idx < m_wr) ? m_mem[idx] : 32'd0;
    end
    return 32'd0;
  endfunction

  function automatic void m_capture(logic [31:0] d);
    if (m_wr < 12) begin
      m_mem[m_wr] = d;
      m_wr++;
    end
    if (m_cnt < 7) m_cnt++;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic capture(logic [31:0] d);
    @(negedge clk);
    cap_valid = 1'b1; cap_data = d;
    @(negedge clk);
    cap_valid = 1'b0;
    m_capture(d);
  endtask

  task automatic clear(bit with_cap);
    @(negedge clk);
    mrr_clr = 1'b1; cap_valid = with_cap; cap_data = 32'hDEAD_0000;
    @(negedge clk);
    mrr_clr = 1'b0; cap_valid = 1'b0;
    m_wr = 0; m_rd = 0; m_cnt = 0;
  endtask

  task automatic apb_read(string req, logic [11:0] a, bit with_cap = 0,
                          logic [31:0] cd = 32'd0);
    logic [31:0] exp;
    int n;
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1; cap_valid = with_cap; cap_data = cd;
    #1;
    exp = m_expect(a);
    check(req, prdata, exp);
    check({req, " pready"}, {31'd0, pready}, 32'd1);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; cap_valid = 1'b0;
    if (a[1:0] == 2'b00 && a >= D0_OFF && a <= dreg(11)) begin
      n = int'((a - D0_OFF) >> 2);
      if (n == 0 && m_rd < m_wr) m_rd++;
      if (n == 11) begin m_rd = 0; m_cnt = 0; end
    end
    if (with_cap) m_capture(cd);
  endtask

  task automatic apb_write(logic [11:0] a);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic t_reset();
    apb_read("R1 status", ST_OFF);
    apb_read("R1 data5", dreg(5));
    apb_read("R1 data0", dreg(0));
    apb_read("R1 status after empty pop", ST_OFF);
  endtask

  task automatic t_capture();
    capture(32'hA0A0_0001);
    capture(32'hB1B1_0002);
    capture(32'hC2C2_0003);
    apb_read("R3 status three", ST_OFF);
    apb_read("R2 data1", dreg(1));
    apb_read("R2 data2", dreg(2));
    apb_read("R5 data3 unwritten", dreg(3));
  endtask

  task automatic t_pop();
    apb_read("R6 pop first", dreg(0));
    apb_read("R6 data1 after pop", dreg(1));
    apb_read("R6 pop second", dreg(0));
    apb_read("R6 pop third", dreg(0));
    apb_read("R6 pop at end", dreg(0));
    apb_read("R6 status unchanged", ST_OFF);
  endtask

  task automatic t_rewind();
    apb_read("R7 data11 read", dreg(11));
    apb_read("R7 status cleared", ST_OFF);
    apb_read("R7 data0 after rewind", dreg(0));
    capture(32'hD3D3_0004);
    apb_read("R7 appended data2", dreg(2));
    apb_read("R7 status one", ST_OFF);
  endtask

  task automatic t_overflow();
    clear(1'b0);
    for (int i = 0; i < 14; i++) capture(32'h5500_0000 + 32'(i));
    apb_read("R3 status saturated", ST_OFF);
    apb_read("R4 data10", dreg(10));
    apb_read("R4 data11 last kept", dreg(11));
    capture(32'h7777_7777);
    apb_read("R4 data11 after drop", dreg(11));
    apb_read("R4 status after drop", ST_OFF);
  endtask

  task automatic t_clear();
    capture(32'h1111_1111);
    clear(1'b1);
    apb_read("R8 status empty", ST_OFF);
    apb_read("R8 data1 empty", dreg(1));
    capture(32'h2222_2222);
    apb_read("R8 refill data1", dreg(1));
    apb_read("R8 refill data0", dreg(0));
  endtask

  task automatic t_bus();
    apb_write(ST_OFF);
    apb_write(dreg(0));
    apb_write(dreg(11));
    apb_read("R10 status after writes", ST_OFF);
    apb_read("R10 data2 after writes", dreg(2));
    apb_read("R10 unmapped", 12'h600);
    apb_read("R10 misaligned", 12'h51D);
    apb_read("R10 below data", 12'h514);
  endtask

  task automatic t_same_cycle();
    clear(1'b0);
    capture(32'h3333_0001);
    capture(32'h3333_0002);
    apb_read("R9 data11 with capture", dreg(11), 1'b1, 32'h4444_0003);
    apb_read("R9 status after", ST_OFF);
    apb_read("R9 new word data2", dreg(2));
  endtask

  initial begin
    rst_n = 1'b0; mrr_clr = 1'b0; cap_valid = 1'b0; cap_data = '0;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0;
    m_wr = 0; m_rd = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_capture();
    t_pop();
    t_rewind();
    t_overflow();
    t_clear();
    t_bus();
    t_same_cycle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule